// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim Handshake

This block gathers up to `NSRC - 1` interrupt sources and sends them to `NCTX` processor contexts, each of which has one interrupt line. ID 0 is reserved. Software programs the block over a simple word-wide register bus. It sets a 3-bit priority for each source, an enable mask for each context, and a threshold for each context. A context's line is raised while that context has an enabled pending source whose priority is strictly above the context's threshold.

To service an interrupt, the handler reads its context's claim register. The read returns the ID of the winning source, clears that source's pending bit, and blocks the source from pending again. When the handler is done, it writes the same ID back to the claim register, which lifts the block. Each source's gateway is either level-sensitive or rising-edge sensitive, as chosen by a parameter mask.

Top module: `intc_claim`

## Requirements
- R1: After reset, every priority, enable and threshold register reads 0, no source is pending, every interrupt line is low, and a claim read returns 0.
- R2: The priority of source N is the word at byte offset 4*N, and only bits [2:0] are stored. The word for ID 0 always reads 0, and writes to it are dropped.
- R3: Context C's enable mask is the word at 0x2000 + 0x80*C + 4*(N/32), and source N is bit N%32 of that word. Bit 0 of word 0 always reads 0. Each context keeps its own mask.
- R4: Context C's threshold is at 0x200000 + 0x1000*C (3 bits). irq_out[C] is high exactly when some pending source that C has enabled has a priority strictly greater than that threshold. A threshold of 7 therefore masks every source.
- R5: A read of offset +4 in context C's control window returns the ID of C's best pending enabled source with a nonzero priority. The highest priority wins, and on a tie the lowest ID wins. The read returns 0 if no such source exists. In the same cycle the read clears that source's pending bit and blocks the source.
- R6: Repeated claim reads return a new ID each time, in priority order, until one returns 0.
- R7: Writing a claimed ID to offset +4 unblocks that source even when its enable bit is clear. A write of 0, of an ID of NSRC or more, or of an ID that is not claimed has no effect.
- R8: A level source becomes pending while its input is high and it is not blocked. If the input is still high when the source is completed, the source is pending again in the next cycle. A blocked source never becomes pending.
- R9: An edge source (its bit set in EDGE_SRC, sources 16 to 31 by default) becomes pending only on a 0-to-1 input change. A held-high input does not make it pending again after completion, and rising edges that arrive while the source is blocked are lost.
- R10: Read data appears on bus_rdata in the cycle after the request. Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Raw interrupt inputs, bit N is source N |
| bus_valid | input | 1 | Register access request, one cycle each |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Byte address, bits [1:0] ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read request |
| irq_out | output | NCTX | Interrupt line for each context |

## Verification
A claim read and the arrival of a new interrupt can happen in the same clock edge. The claim acts on the pending set as it was registered before that edge, while the new source is added at the same edge. The bench issues a claim read on the exact cycle that a higher-priority edge source rises. It expects the read to return the older, lower-priority ID, and the next claim read to return the new source's ID. This shows that the arrival was neither lost nor taken early.

// File: rtl/intc_claim.sv
module intc_claim #(
  parameter int NSRC = 32,
  parameter int NCTX = 2,
  parameter int PW = 3,
  parameter int AW = 26,
  parameter logic [NSRC-1:0] EDGE_SRC = 32'hFFFF_0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCTX-1:0] irq_out
);
  localparam int IDW = $clog2(NSRC);
  localparam int NW = (NSRC + 31) / 32;
  localparam int EW = NW * 32;
  localparam int EN_BASE = 32'h2000;
  localparam int EN_STRIDE = 32'h80;
  localparam int CTX_BASE = 32'h20_0000;
  localparam int CTX_STRIDE = 32'h1000;
  localparam logic [EW-1:0] LIVE = (EW'(1) << NSRC) - EW'(2);
  localparam logic [NSRC-1:0] LIVE_S = LIVE[NSRC-1:0];

  logic [PW-1:0]   prio [NSRC];
  logic [EW-1:0]   en [NCTX];
  logic [PW-1:0]   thr [NCTX];
  logic [NSRC-1:0] pend, gate, src_q, rise, arrive, take, drop;
  logic [IDW-1:0]  win_id [NCTX];
  logic [PW-1:0]   win_pr [NCTX];
  logic [31:0]     rd_c;
  logic            claim_any, claim_q;

  wire [AW-1:0] wa = {bus_addr[AW-1:2], 2'b00};
  wire rd = bus_valid & ~bus_write;
  wire wr = bus_valid & bus_write;

  function automatic logic [AW-1:0] ctl_addr(input int c, input int off);
    return AW'(CTX_BASE + c * CTX_STRIDE + off);
  endfunction

  function automatic logic [AW-1:0] en_addr(input int c, input int w);
    return AW'(EN_BASE + c * EN_STRIDE + 4 * w);
  endfunction

  assign rise = src_in & ~src_q;
  assign arrive = ~gate & LIVE_S & ((EDGE_SRC & rise) | (~EDGE_SRC & src_in));

  always_comb begin
    for (int c = 0; c < NCTX; c++) begin
      win_id[c] = '0;
      win_pr[c] = '0;
      for (int i = 1; i < NSRC; i++)
        if (pend[i] && en[c][i] && prio[i] > win_pr[c]) begin
          win_pr[c] = prio[i];
          win_id[c] = IDW'(i);
        end
    end
  end

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_line
      assign irq_out[c] = win_pr[c] > thr[c];
    end
  endgenerate

  always_comb begin
    take = '0;
    drop = '0;
    claim_any = 1'b0;
    for (int c = 0; c < NCTX; c++) begin
      if (rd && wa == ctl_addr(c, 4)) begin
        claim_any = 1'b1;
        take = (NSRC'(1) << win_id[c]) & LIVE_S;
      end
      if (wr && wa == ctl_addr(c, 4) && bus_wdata < 32'(NSRC))
        drop = gate & (NSRC'(1) << bus_wdata[IDW-1:0]);
    end
  end

  always_comb begin
    rd_c = '0;
    for (int i = 1; i < NSRC; i++)
      if (wa == AW'(4 * i)) rd_c = 32'(prio[i]);
    for (int c = 0; c < NCTX; c++) begin
      for (int w = 0; w < NW; w++)
        if (wa == en_addr(c, w)) rd_c = en[c][w*32 +: 32];
      if (wa == ctl_addr(c, 0)) rd_c = 32'(thr[c]);
      if (wa == ctl_addr(c, 4)) rd_c = 32'(win_id[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
      pend      <= '0;
      gate      <= '0;
      src_q     <= '0;
      bus_rdata <= '0;
      claim_q   <= 1'b0;
    end else begin
      src_q     <= src_in;
      pend      <= (pend | arrive) & ~take;
      gate      <= (gate | take) & ~drop;
      bus_rdata <= rd ? rd_c : '0;
      claim_q   <= claim_any;
      if (wr) begin
        for (int i = 1; i < NSRC; i++)
          if (wa == AW'(4 * i)) prio[i] <= bus_wdata[PW-1:0];
        for (int c = 0; c < NCTX; c++) begin
          for (int w = 0; w < NW; w++)
            if (wa == en_addr(c, w)) en[c][w*32 +: 32] <= bus_wdata & LIVE[w*32 +: 32];
          if (wa == ctl_addr(c, 0)) thr[c] <= bus_wdata[PW-1:0];
        end
      end
    end
  end

  assert_claim_gates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_q && bus_rdata != 32'd0) |-> (gate[bus_rdata[IDW-1:0]] && !pend[bus_rdata[IDW-1:0]]));

  assert_claim_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_q |-> bus_rdata < 32'(NSRC));

  assert_gated_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend & $past(gate & ~pend)) == '0);

  generate
    for (genvar c = 0; c < NCTX; c++) begin : g_chk
      assert_thr_max_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[c] |-> thr[c] != '1);
      assert_irq_backed_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[c] |-> (pend & en[c][NSRC-1:0]) != '0);
    end
  endgenerate
endmodule

// File: tb/intc_claim_test.sv
`timescale 1ns/1ps
module intc_claim_test;
  localparam int NSRC = 32;
  localparam int NCTX = 2;
  localparam int AW = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic bv = 1'b0, bw = 1'b0;
  logic [AW-1:0] ba = '0;
  logic [31:0] bwd = '0;
  wire [31:0] brd;
  wire [NCTX-1:0] irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  intc_claim #(.NSRC(NSRC), .NCTX(NCTX), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_valid(bv), .bus_write(bw),
    .bus_addr(ba), .bus_wdata(bwd), .bus_rdata(brd), .irq_out(irq));

  function automatic logic [31:0] pa(input int n); return 32'(4 * n); endfunction
  function automatic logic [31:0] enb(input int c); return 32'h2000 + 32'h80 * 32'(c); endfunction
  function automatic logic [31:0] tha(input int c); return 32'h20_0000 + 32'h1000 * 32'(c); endfunction
  function automatic logic [31:0] clm(input int c); return tha(c) + 32'd4; endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk); bv = 1'b1; bw = 1'b1; ba = AW'(a); bwd = d;
    @(negedge clk); bv = 1'b0; bw = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk); bv = 1'b1; bw = 1'b0; ba = AW'(a);
    @(negedge clk); bv = 1'b0; d = brd;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq after reset", 32'(irq), 32'h0);
    rd(pa(5), d);    check("R1 prio reset", d, 32'h0);
    rd(tha(0), d);   check("R1 threshold reset", d, 32'h0);
    rd(enb(0), d);   check("R1 enable reset", d, 32'h0);
    rd(clm(0), d);   check("R1 claim empty", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(pa(5), 32'hFFFF_FFFF); rd(pa(5), d); check("R2 prio width", d, 32'h7);
    wr(pa(0), 32'h3);         rd(pa(0), d); check("R2 id0 prio", d, 32'h0);
    wr(enb(1), 32'hFFFF_FFFF); rd(enb(1), d); check("R3 enable bit0 zero", d, 32'hFFFF_FFFE);
    rd(enb(0), d); check("R3 separate masks", d, 32'h0);
    wr(enb(1), 32'h0);
    wr(tha(1), 32'h5); rd(tha(1), d); check("R4 threshold store", d, 32'h5);
    wr(tha(1), 32'h0);
    wr(32'h100, 32'hABCD); rd(32'h100, d); check("R10 unmapped prio area", d, 32'h0);
    rd(enb(2), d); check("R10 unmapped enable area", d, 32'h0);
    wr(pa(5), 32'h0);
  endtask

  task automatic t_threshold;
    logic [31:0] d;
    wr(pa(3), 32'h2); wr(enb(0), 32'h8); wr(tha(0), 32'h2);
    src[3] = 1'b1; idle(2);
    check("R4 equal priority masked", 32'(irq[0]), 32'h0);
    wr(tha(0), 32'h1); idle(1);
    check("R4 above threshold", 32'(irq[0]), 32'h1);
    check("R4 other context quiet", 32'(irq[1]), 32'h0);
    wr(pa(3), 32'h7); wr(tha(0), 32'h7); idle(1);
    check("R4 threshold 7 masks", 32'(irq[0]), 32'h0);
    wr(pa(3), 32'h2); wr(tha(0), 32'h0);
    src[3] = 1'b0;
    rd(clm(0), d); check("R5 claim sticky level", d, 32'd3);
    wr(clm(0), 32'd3);
  endtask

  task automatic t_order;
    logic [31:0] d;
    wr(pa(4), 32'h5); wr(pa(6), 32'h5); wr(pa(3), 32'h2);
    wr(enb(0), 32'h58);
    src[3] = 1'b1; src[4] = 1'b1; src[6] = 1'b1; idle(2);
    check("R4 line up", 32'(irq[0]), 32'h1);
    rd(clm(0), d); check("R5 tie lowest id", d, 32'd4);
    rd(clm(0), d); check("R6 second claim", d, 32'd6);
    rd(clm(0), d); check("R6 third claim", d, 32'd3);
    rd(clm(0), d); check("R6 drained", d, 32'd0);
    check("R5 line drops after claims", 32'(irq[0]), 32'h0);
    wr(clm(0), 32'd4); idle(1);
    rd(clm(0), d); check("R8 level re-pends", d, 32'd4);
    src[3] = 1'b0; src[4] = 1'b0; src[6] = 1'b0; idle(1);
    wr(clm(0), 32'd4); wr(clm(0), 32'd6); wr(clm(0), 32'd3); idle(1);
    rd(clm(0), d); check("R8 low level stays idle", d, 32'd0);
  endtask

  task automatic t_complete;
    logic [31:0] d;
    wr(pa(7), 32'h4); wr(enb(0), 32'h80);
    src[7] = 1'b1; idle(2);
    rd(clm(0), d); check("R5 claim 7", d, 32'd7);
    wr(clm(0), 32'd40); wr(clm(0), 32'd9); wr(clm(0), 32'd0); idle(1);
    rd(clm(0), d); check("R7 bad completions ignored", d, 32'd0);
    wr(enb(0), 32'h0);
    wr(clm(0), 32'd7); idle(1);
    wr(enb(0), 32'h80); idle(1);
    rd(clm(0), d); check("R7 complete while disabled", d, 32'd7);
    src[7] = 1'b0; idle(1);
    wr(clm(0), 32'd7); idle(1);
    rd(clm(0), d); check("R7 cleanup", d, 32'd0);
  endtask

  task automatic t_edge;
    logic [31:0] d;
    wr(pa(20), 32'h3); wr(enb(0), 32'h0010_0000);
    src[20] = 1'b1; idle(2);
    rd(clm(0), d); check("R9 edge pends", d, 32'd20);
    wr(clm(0), 32'd20); idle(2);
    rd(clm(0), d); check("R9 held high no re-pend", d, 32'd0);
    src[20] = 1'b0; idle(1); src[20] = 1'b1; idle(2);
    rd(clm(0), d); check("R9 new edge pends", d, 32'd20);
    src[20] = 1'b0; idle(1); src[20] = 1'b1; idle(2);
    wr(clm(0), 32'd20); idle(1);
    rd(clm(0), d); check("R9 edge while blocked lost", d, 32'd0);
    src[20] = 1'b0;
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(pa(5), 32'h1); wr(pa(21), 32'h6);
    wr(enb(0), 32'h0020_0020);
    src[5] = 1'b1; idle(2);
    @(negedge clk); bv = 1'b1; bw = 1'b0; ba = AW'(clm(0)); src[21] = 1'b1;
    @(negedge clk); bv = 1'b0; d = brd;
    check("R5 claim uses prior pending set", d, 32'd5);
    rd(clm(0), d); check("R6 arrival kept", d, 32'd21);
    rd(clm(1), d); check("R5 other context empty", d, 32'd0);
    src[5] = 1'b0; src[21] = 1'b0; idle(1);
    wr(clm(0), 32'd5); wr(clm(0), 32'd21); idle(1);
    rd(clm(0), d); check("R6 final drain", d, 32'd0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset;
    t_regs;
    t_threshold;
    t_order;
    t_complete;
    t_edge;
    t_same_cycle;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule